// File: doc/BRIEF.md
# Hash Descriptor Front End

This block sits in front of a hash compression core and runs it from descriptors placed in memory. Software writes `0xF` to the status register to clear it. It then writes a descriptor address with bit 1 set to the start register. The block reads the descriptor, which is three 32-bit words: a configuration word, a source address and a destination address. It decodes the configuration, resets the core if the descriptor opens a message, and streams the data bytes to the core one word at a time. If the descriptor closes the message, the block collects the digest from the core and writes it to the destination.

A message may span several descriptors placed back to back in memory. Only the first one carries the opening flag and only the last one carries the closing flag, so the core's running state carries over between them. After each descriptor the configuration word is written back with its ownership bit cleared. When the descriptor marked as the end of the list is finished, the block sets the status register and raises a one-cycle done pulse. A descriptor that software does not own, or that selects an unknown algorithm, stops the run with the error bit set.

Top module: `hash_desc_ctrl`

## Requirements
- R1: After a launch, the block reads the configuration word at the descriptor address A, then the source address at A+4, then the destination address at A+8, before any data read.
- R2: A write to the start register (`reg_sel`=1) launches a run only if bit 1 of the written value is set and the block is idle. The descriptor address is the written value with bits 1:0 forced to zero. Any other start write is ignored.
- R3: Status (`stat_o`) is cleared to 0 at launch and reads 0 while a run is in progress. A status write (`reg_sel`=0) with bits 3:0 equal to 0xF clears it. A status write with any other value leaves it unchanged.
- R4: If configuration bit 31 (ownership) is clear, the block sets `stat_o` to 2'b11 and returns to idle. It pulses no core signal and performs no memory write.
- R5: Configuration bits 23:20 select the algorithm: 0x6 drives `core_alg224`=0 (SHA-256) and 0x7 drives `core_alg224`=1 (SHA-224). Any other value is handled as in R4.
- R6: When configuration bit 24 is set, `core_init` pulses for one cycle before the first data beat of that descriptor. When bit 24 is clear, there is no pulse and the core state carries over from the previous descriptor.
- R7: Configuration bits 16:0 give a byte length L. The block sends ceil(L/4) beats, taken from consecutive words starting at the source address. Each beat carries 4 bytes, except the last, which carries L mod 4 bytes when that is nonzero. L=0 sends no beat.
- R8: When configuration bit 25 is set, `core_finish` pulses once after the last beat. The digest is then written to destination+4*i, most significant word first: 8 words for SHA-256, 7 for SHA-224. When bit 25 is clear, there is no finish pulse and no digest write.
- R9: After its data and digest are handled, each descriptor's configuration word is written back to its own address with bit 31 cleared and every other bit unchanged.
- R10: When configuration bit 18 is set, the run ends after that descriptor. When it is clear, the next descriptor is read at the descriptor address plus 12.
- R11: A successful run sets `stat_o` to 2'b01. Each finished run, whether successful or failed, raises `done_o` for exactly one cycle, in the same cycle that `stat_o` becomes nonzero.
- R12: A memory read or write request holds its address (and write data) stable until acknowledged. A data beat holds its data and byte count stable until the core accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 start |
| reg_wdata | input | 32 | Register write value |
| stat_o | output | 2 | Status: bit 0 finished, bit 1 error |
| done_o | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Write acknowledge |
| core_init | output | 1 | Reset core to initial hash state |
| core_alg224 | output | 1 | Algorithm select, 1 = SHA-224 |
| core_valid | output | 1 | Data beat valid |
| core_data | output | 32 | Data beat, lowest byte first |
| core_nbytes | output | 3 | Valid bytes in beat (1 to 4) |
| core_ready | input | 1 | Core accepts beat |
| core_finish | output | 1 | Close message, request digest |
| core_dig_valid | input | 1 | Digest valid pulse |
| core_digest | input | 256 | Digest, first word in the top bits |

## Verification
The hardest case to reach is a message that continues through a descriptor with neither the opening nor the closing flag set. A wrongly placed core reset or digest write in that case only shows up as a changed final digest or an extra memory write. The bench builds a three-descriptor list with partial-word lengths, and its core model folds every beat into a running value. The final digest therefore depends on state that survived each descriptor boundary. During that run the bench also issues a second launch aimed at a descriptor that software does not own, which proves a launch while busy is dropped. A SHA-224 job with a sentinel in the eighth destination word checks that the shorter digest stops at seven words.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 17;
  localparam int EOL_BIT   = 18;
  localparam int ALG_LSB   = 20;
  localparam int ALG_W     = 4;
  localparam int FIRST_BIT = 24;
  localparam int LAST_BIT  = 25;
  localparam int OWN_BIT   = 31;
  localparam int START_BIT = 1;
  localparam logic [ALG_W-1:0] ALG_SHA256 = 4'h6;
  localparam logic [ALG_W-1:0] ALG_SHA224 = 4'h7;
  localparam logic [3:0]       CLR_KEY    = 4'hF;

  typedef struct packed {
    logic             owned;
    logic             eol;
    logic             first;
    logic             last;
    logic             alg_ok;
    logic             alg224;
    logic [LEN_W-1:0] len;
  } desc_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RDCFG, S_RDSRC, S_RDDST, S_CHECK, S_INIT, S_FETCH,
    S_RDDATA, S_FEED, S_FINISH, S_WAITDIG, S_WRDIG, S_WRCFG
  } fsm_t;
endpackage

// File: rtl/hdc_cfg_decode.sv
module hdc_cfg_decode
  import hdc_pkg::*;
(
  input  logic [WORD_W-1:0] cfg_word,
  output desc_cfg_t         dec,
  output logic [WORD_W-1:0] wb_word
);
  logic [ALG_W-1:0] alg;

  always_comb begin
    alg        = cfg_word[ALG_LSB +: ALG_W];
    dec.owned  = cfg_word[OWN_BIT];
    dec.eol    = cfg_word[EOL_BIT];
    dec.first  = cfg_word[FIRST_BIT];
    dec.last   = cfg_word[LAST_BIT];
    dec.alg_ok = (alg == ALG_SHA256) || (alg == ALG_SHA224);
    dec.alg224 = (alg == ALG_SHA224);
    dec.len    = cfg_word[LEN_W-1:0];
    wb_word    = cfg_word;
    wb_word[OWN_BIT] = 1'b0;
  end
endmodule

// File: rtl/hdc_len_track.sv
module hdc_len_track #(
  parameter int LEN_W  = 17,
  parameter int BEAT_B = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             step,
  output logic             empty,
  output logic [2:0]       nbytes
);
  localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_B);

  logic [LEN_W-1:0] rem_q;

  always_comb begin
    empty  = (rem_q == '0);
    nbytes = (rem_q >= BEAT_L) ? 3'(BEAT_B) : 3'(rem_q);
  end

  always_ff @(posedge clk) begin
    if (rst)       rem_q <= '0;
    else if (load) rem_q <= len_in;
    else if (step) rem_q <= rem_q - LEN_W'(nbytes);
  end
endmodule

// File: rtl/hdc_status_reg.sv
module hdc_status_reg #(
  parameter int STAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              clr,
  input  logic              set_ok,
  input  logic              set_err,
  output logic [STAT_W-1:0] stat_q,
  output logic              done_q
);
  localparam logic [STAT_W-1:0] ST_OK  = STAT_W'(1);
  localparam logic [STAT_W-1:0] ST_ERR = STAT_W'(3);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= set_ok | set_err;
      if (set_err)             stat_q <= ST_ERR;
      else if (set_ok)         stat_q <= ST_OK;
      else if (launch || clr)  stat_q <= '0;
    end
  end
endmodule

// File: rtl/hash_desc_ctrl.sv
module hash_desc_ctrl
  import hdc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIG_W  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [1:0]        stat_o,
  output logic              done_o,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              core_init,
  output logic              core_alg224,
  output logic              core_valid,
  output logic [WORD_W-1:0] core_data,
  output logic [2:0]        core_nbytes,
  input  logic              core_ready,
  output logic              core_finish,
  input  logic              core_dig_valid,
  input  logic [DIG_W-1:0]  core_digest
);
  localparam int DIG_WORDS = DIG_W / WORD_W;
  localparam int IDX_W     = $clog2(DIG_WORDS);
  localparam logic [IDX_W-1:0]  LAST_L = IDX_W'(DIG_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_S = IDX_W'(DIG_WORDS - 2);
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(WORD_W / 8);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(3 * WORD_W / 8);

  fsm_t              st;
  logic [ADDR_W-1:0] desc_a, src_a, dst_a;
  logic [WORD_W-1:0] cfg_q, wb_word;
  desc_cfg_t         dec;
  logic [DIG_W-1:0]  dig_q;
  logic [IDX_W-1:0]  dig_idx;
  logic              len_load, len_step, len_empty;
  logic [2:0]        len_nb;
  logic              launch, stat_clr, set_ok, set_err;
  logic [ADDR_W-1:0] start_a;

  hdc_cfg_decode u_dec (
    .cfg_word (cfg_q),
    .dec      (dec),
    .wb_word  (wb_word)
  );

  hdc_len_track #(.LEN_W(LEN_W), .BEAT_B(WORD_W / 8)) u_len (
    .clk    (clk),
    .rst    (rst),
    .load   (len_load),
    .len_in (dec.len),
    .step   (len_step),
    .empty  (len_empty),
    .nbytes (len_nb)
  );

  hdc_status_reg #(.STAT_W(2)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .clr     (stat_clr),
    .set_ok  (set_ok),
    .set_err (set_err),
    .stat_q  (stat_o),
    .done_q  (done_o)
  );

  always_comb begin
    start_a  = ADDR_W'({reg_wdata[WORD_W-1:2], 2'b00});
    launch   = reg_we && reg_sel && reg_wdata[START_BIT] && (st == S_IDLE);
    stat_clr = reg_we && !reg_sel && (reg_wdata[3:0] == CLR_KEY) && reg_wdata[0];
    set_err  = (st == S_CHECK) && (!dec.owned || !dec.alg_ok);
    set_ok   = (st == S_WRCFG) && wr_ack && dec.eol;
    len_load = (st == S_CHECK);
    len_step = (st == S_RDDATA) && rd_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      desc_a      <= '0;
      src_a       <= '0;
      dst_a       <= '0;
      cfg_q       <= '0;
      dig_q       <= '0;
      dig_idx     <= '0;
      rd_req      <= 1'b0;
      rd_addr     <= '0;
      wr_req      <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      core_init   <= 1'b0;
      core_alg224 <= 1'b0;
      core_valid  <= 1'b0;
      core_data   <= '0;
      core_nbytes <= '0;
      core_finish <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (launch) begin
            desc_a  <= start_a;
            rd_addr <= start_a;
            rd_req  <= 1'b1;
            st      <= S_RDCFG;
          end
        end
        S_RDCFG: begin
          if (rd_ack) begin
            cfg_q   <= rd_data;
            rd_addr <= desc_a + STEP;
            st      <= S_RDSRC;
          end
        end
        S_RDSRC: begin
          if (rd_ack) begin
            src_a   <= ADDR_W'(rd_data);
            rd_addr <= desc_a + STEP + STEP;
            st      <= S_RDDST;
          end
        end
        S_RDDST: begin
          if (rd_ack) begin
            dst_a  <= ADDR_W'(rd_data);
            rd_req <= 1'b0;
            st     <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (set_err) begin
            st <= S_IDLE;
          end else begin
            core_alg224 <= dec.alg224;
            if (dec.first) begin
              core_init <= 1'b1;
              st        <= S_INIT;
            end else begin
              st <= S_FETCH;
            end
          end
        end
        S_INIT: begin
          core_init <= 1'b0;
          st        <= S_FETCH;
        end
        S_FETCH: begin
          if (!len_empty) begin
            rd_req  <= 1'b1;
            rd_addr <= src_a;
            st      <= S_RDDATA;
          end else if (dec.last) begin
            core_finish <= 1'b1;
            st          <= S_FINISH;
          end else begin
            wr_req  <= 1'b1;
            wr_addr <= desc_a;
            wr_data <= wb_word;
            st      <= S_WRCFG;
          end
        end
        S_RDDATA: begin
          if (rd_ack) begin
            rd_req      <= 1'b0;
            core_valid  <= 1'b1;
            core_data   <= rd_data;
            core_nbytes <= len_nb;
            src_a       <= src_a + STEP;
            st          <= S_FEED;
          end
        end
        S_FEED: begin
          if (core_ready) begin
            core_valid <= 1'b0;
            st         <= S_FETCH;
          end
        end
        S_FINISH: begin
          core_finish <= 1'b0;
          st          <= S_WAITDIG;
        end
        S_WAITDIG: begin
          if (core_dig_valid) begin
            dig_q   <= core_digest;
            dig_idx <= '0;
            wr_req  <= 1'b1;
            wr_addr <= dst_a;
            wr_data <= core_digest[DIG_W-1 -: WORD_W];
            st      <= S_WRDIG;
          end
        end
        S_WRDIG: begin
          if (wr_ack) begin
            if (dig_idx == (core_alg224 ? LAST_S : LAST_L)) begin
              wr_addr <= desc_a;
              wr_data <= wb_word;
              st      <= S_WRCFG;
            end else begin
              dig_idx <= dig_idx + 1'b1;
              wr_addr <= wr_addr + STEP;
              wr_data <= dig_q[DIG_W-WORD_W-1 -: WORD_W];
              dig_q   <= {dig_q[DIG_W-WORD_W-1:0], dig_q[DIG_W-1 -: WORD_W]};
            end
          end
        end
        S_WRCFG: begin
          if (wr_ack) begin
            wr_req <= 1'b0;
            if (dec.eol) begin
              st <= S_IDLE;
            end else begin
              desc_a  <= desc_a + STRIDE;
              rd_addr <= desc_a + STRIDE;
              rd_req  <= 1'b1;
              st      <= S_RDCFG;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdc_chk.sv
module hdc_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  stat_o,
  input logic        done_o,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic        rd_ack,
  input logic        wr_req,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        wr_ack,
  input logic        core_init,
  input logic        core_valid,
  input logic [31:0] core_data,
  input logic [2:0]  core_nbytes,
  input logic        core_ready,
  input logic        core_finish
);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  // R12
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    core_valid && !core_ready |=> core_valid && $stable(core_data) && $stable(core_nbytes));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11
  done_stat_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> stat_o != 2'b00);

  // R3
  busy_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_req || core_valid) |-> stat_o == 2'b00);

  // R6
  init_alone_chk: assert property (@(posedge clk) disable iff (rst)
    core_init |-> !core_valid && !core_finish);

  // R6
  init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_init |=> !core_init);

  // R7
  nbytes_range_chk: assert property (@(posedge clk) disable iff (rst)
    core_valid |-> (core_nbytes != 3'd0) && (core_nbytes <= 3'd4));

  // R8
  finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_finish |=> !core_finish);
endmodule

bind hash_desc_ctrl hdc_chk u_hdc_chk (.*);

// File: tb/test_hash_desc_ctrl.sv
module test_hash_desc_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [1:0]   stat_o;
  logic         done_o;
  logic         rd_req, rd_ack = 1'b0;
  logic [31:0]  rd_addr, rd_data = '0;
  logic         wr_req, wr_ack = 1'b0;
  logic [31:0]  wr_addr, wr_data;
  logic         core_init, core_alg224, core_valid, core_finish;
  logic [31:0]  core_data;
  logic [2:0]   core_nbytes;
  logic         core_ready = 1'b0, core_dig_valid = 1'b0;
  logic [255:0] core_digest = '0;

  always #4 clk = ~clk;

  hash_desc_ctrl i_hash_desc_ctrl (.*);

  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, init_cnt = 0, beat_cnt = 0, fin_cnt = 0, done_cnt = 0, viol = 0;
  logic [31:0] rd_log [0:63];
  logic [31:0] acc = '0, tot = '0;
  logic        last_sel = 1'b0;
  int          dtimer = 0;
  logic        vq = 0, rq = 0, mrq = 0, maq = 0, mwq = 0, mwa = 0;

  function automatic logic [31:0] seed(input logic s224);
    return s224 ? 32'hC105_9ED8 : 32'h6A09_E667;
  endfunction

  function automatic logic [31:0] fold(input logic [31:0] a, input logic [31:0] w, input logic [2:0] nb);
    logic [31:0] m;
    m = (nb >= 3'd4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
    return ({a[26:0], a[31:27]} ^ (w & m)) + {29'b0, nb};
  endfunction

  function automatic logic [31:0] dword(input logic [31:0] a, input logic [31:0] t, input int i);
    return a ^ t ^ (i * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] cfgw(input bit own, input bit eol, input logic [3:0] alg,
                                      input bit first, input bit last, input int len);
    return ({31'b0, own} << 31) | ({31'b0, last} << 25) | ({31'b0, first} << 24) |
           ({28'b0, alg} << 20) | ({31'b0, eol} << 18) | (len & 32'h1FFFF);
  endfunction

  function automatic logic [31:0] fold_chunk(input logic [31:0] a, input int wbase, input int len);
    logic [31:0] r;
    r = a;
    for (int k = 0; k < len; k += 4)
      r = fold(r, mem[wbase + k / 4], (len - k >= 4) ? 3'd4 : 3'(len - k));
    return r;
  endfunction

  // memory model
  always @(posedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack <= 1'b1;
      rd_data <= mem[rd_addr[11:2]];
      rd_log[rd_cnt % 64] <= rd_addr;
      rd_cnt <= rd_cnt + 1;
    end else rd_ack <= 1'b0;
    if (wr_req && !wr_ack) begin
      wr_ack <= 1'b1;
      mem[wr_addr[11:2]] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end else wr_ack <= 1'b0;
  end

  // hash core model and monitors
  always @(posedge clk) begin
    core_ready <= ~core_ready;
    core_dig_valid <= 1'b0;
    if (core_init) begin
      acc <= seed(core_alg224);
      tot <= '0;
      last_sel <= core_alg224;
      init_cnt <= init_cnt + 1;
    end else if (core_valid && core_ready) begin
      acc <= fold(acc, core_data, core_nbytes);
      tot <= tot + {29'b0, core_nbytes};
      beat_cnt <= beat_cnt + 1;
    end
    if (core_finish) begin
      fin_cnt <= fin_cnt + 1;
      dtimer <= 3;
    end else if (dtimer != 0) begin
      dtimer <= dtimer - 1;
      if (dtimer == 1) begin
        core_dig_valid <= 1'b1;
        for (int i = 0; i < 8; i++) core_digest[255 - 32 * i -: 32] <= dword(acc, tot, i);
      end
    end
    if (done_o) done_cnt <= done_cnt + 1;
    vq <= core_valid; rq <= core_ready;
    mrq <= rd_req; maq <= rd_ack; mwq <= wr_req; mwa <= wr_ack;
    if (!rst && ((vq && !rq && !core_valid) || (mrq && !maq && !rd_req) || (mwq && !mwa && !wr_req)))
      viol <= viol + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic run_job(input logic [31:0] da, input bit busy_poke);
    int n;
    reg_write(1'b1, da | 32'h2);
    chk(stat_o == 2'b00, "R3 status zero after launch", {30'b0, stat_o}, 0);
    if (busy_poke) reg_write(1'b1, 32'h302);
    n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R11 run completes", n, 0);
    chk(stat_o != 2'b00, "R11 status nonzero with done", {30'b0, stat_o}, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(input int wbase, input int n);
    for (int i = 0; i < n; i++) mem[wbase + i] = 32'hDEAD_BEEF;
  endtask

  task automatic t_reset();
    chk(stat_o == 2'b00, "R3 reset status", {30'b0, stat_o}, 0);
    chk(!done_o, "R11 reset done", {31'b0, done_o}, 0);
    chk(!rd_req && !wr_req, "R1 reset no request", {30'b0, rd_req, wr_req}, 0);
    chk(!core_valid && !core_init, "R6 reset core idle", {30'b0, core_valid, core_init}, 0);
  endtask

  task automatic t_single256();
    int r0, d0, i0, b0, f0;
    logic [31:0] a;
    mem[64] = cfgw(1, 1, 4'h6, 1, 1, 10); mem[65] = 32'h400; mem[66] = 32'h800;
    fill(512, 8);
    r0 = rd_cnt; d0 = done_cnt; i0 = init_cnt; b0 = beat_cnt; f0 = fin_cnt;
    run_job(32'h100, 0);
    chk(rd_log[r0 % 64] == 32'h100, "R1 first read cfg", rd_log[r0 % 64], 32'h100);
    chk(rd_log[(r0 + 1) % 64] == 32'h104, "R1 second read src", rd_log[(r0 + 1) % 64], 32'h104);
    chk(rd_log[(r0 + 2) % 64] == 32'h108, "R1 third read dst", rd_log[(r0 + 2) % 64], 32'h108);
    chk(rd_log[(r0 + 3) % 64] == 32'h400, "R7 data from src", rd_log[(r0 + 3) % 64], 32'h400);
    a = fold_chunk(seed(0), 256, 10);
    for (int i = 0; i < 8; i++)
      chk(mem[512 + i] == dword(a, 10, i), "R8 sha256 digest word", mem[512 + i], dword(a, 10, i));
    chk(mem[64] == cfgw(0, 1, 4'h6, 1, 1, 10), "R9 cfg write-back", mem[64], cfgw(0, 1, 4'h6, 1, 1, 10));
    chk(stat_o == 2'b01, "R11 ok status", {30'b0, stat_o}, 1);
    chk(done_cnt - d0 == 1, "R11 one done pulse", done_cnt - d0, 1);
    chk(init_cnt - i0 == 1, "R6 init pulse", init_cnt - i0, 1);
    chk(beat_cnt - b0 == 3, "R7 beats for 10 bytes", beat_cnt - b0, 3);
    chk(fin_cnt - f0 == 1, "R8 finish pulse", fin_cnt - f0, 1);
    chk(last_sel == 1'b0, "R5 mode 6 is sha256", {31'b0, last_sel}, 0);
  endtask

  task automatic t_empty224();
    int b0, w0;
    logic [31:0] a;
    mem[80] = cfgw(1, 1, 4'h7, 1, 1, 0); mem[81] = 32'h400; mem[82] = 32'h900;
    fill(576, 8);
    b0 = beat_cnt; w0 = wr_cnt;
    run_job(32'h140, 0);
    a = seed(1);
    for (int i = 0; i < 7; i++)
      chk(mem[576 + i] == dword(a, 0, i), "R8 sha224 digest word", mem[576 + i], dword(a, 0, i));
    chk(mem[583] == 32'hDEAD_BEEF, "R8 sha224 eighth word untouched", mem[583], 32'hDEAD_BEEF);
    chk(beat_cnt - b0 == 0, "R7 zero length no beat", beat_cnt - b0, 0);
    chk(wr_cnt - w0 == 8, "R9 seven digest plus cfg", wr_cnt - w0, 8);
    chk(last_sel == 1'b1, "R5 mode 7 is sha224", {31'b0, last_sel}, 1);
  endtask

  task automatic t_list();
    int i0, f0, w0, b0;
    logic [31:0] a;
    mem[128] = cfgw(1, 0, 4'h6, 1, 0, 8); mem[129] = 32'h480; mem[130] = 32'hA00;
    mem[131] = cfgw(1, 0, 4'h6, 0, 0, 5); mem[132] = 32'h500; mem[133] = 32'hA00;
    mem[134] = cfgw(1, 1, 4'h6, 0, 1, 7); mem[135] = 32'h580; mem[136] = 32'hA00;
    mem[192] = cfgw(0, 1, 4'h6, 1, 1, 4); mem[193] = 32'h400; mem[194] = 32'hB00;
    fill(640, 8);
    i0 = init_cnt; f0 = fin_cnt; w0 = wr_cnt; b0 = beat_cnt;
    run_job(32'h200, 1);
    a = fold_chunk(fold_chunk(fold_chunk(seed(0), 288, 8), 320, 5), 352, 7);
    for (int i = 0; i < 8; i++)
      chk(mem[640 + i] == dword(a, 20, i), "R6 continued digest word", mem[640 + i], dword(a, 20, i));
    chk(init_cnt - i0 == 1, "R6 init only on first", init_cnt - i0, 1);
    chk(fin_cnt - f0 == 1, "R8 finish only on last", fin_cnt - f0, 1);
    chk(beat_cnt - b0 == 6, "R7 beats across list", beat_cnt - b0, 6);
    chk(wr_cnt - w0 == 11, "R8 digest only on last", wr_cnt - w0, 11);
    chk(mem[131] == cfgw(0, 0, 4'h6, 0, 0, 5), "R10 next at plus 12", mem[131], cfgw(0, 0, 4'h6, 0, 0, 5));
    chk(mem[134] == cfgw(0, 1, 4'h6, 0, 1, 7), "R9 last cfg write-back", mem[134], cfgw(0, 1, 4'h6, 0, 1, 7));
    chk(stat_o == 2'b01, "R2 launch while busy ignored", {30'b0, stat_o}, 1);
  endtask

  task automatic t_error(input logic [31:0] da, input string tag);
    int i0, w0, b0, d0;
    i0 = init_cnt; w0 = wr_cnt; b0 = beat_cnt; d0 = done_cnt;
    run_job(da, 0);
    chk(stat_o == 2'b11, tag, {30'b0, stat_o}, 3);
    chk(init_cnt - i0 == 0 && beat_cnt - b0 == 0, "R4 core untouched", init_cnt - i0 + beat_cnt - b0, 0);
    chk(wr_cnt - w0 == 0, "R4 no memory write", wr_cnt - w0, 0);
    chk(done_cnt - d0 == 1, "R11 done on error", done_cnt - d0, 1);
  endtask

  task automatic t_status_write();
    reg_write(1'b0, 32'h1);
    chk(stat_o == 2'b11, "R3 non-key write ignored", {30'b0, stat_o}, 3);
    reg_write(1'b0, 32'hF);
    chk(stat_o == 2'b00, "R3 key write clears", {30'b0, stat_o}, 0);
  endtask

  task automatic t_nolaunch();
    int r0;
    reg_write(1'b0, 32'hF);
    r0 = rd_cnt;
    reg_write(1'b1, 32'h100);
    repeat (10) @(negedge clk);
    chk(rd_cnt - r0 == 0, "R2 start without bit 1 ignored", rd_cnt - r0, 0);
    chk(stat_o == 2'b00 && !done_o, "R2 no status change", {30'b0, stat_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single256();
    t_empty224();
    t_list();
    mem[192] = cfgw(0, 1, 4'h6, 1, 1, 4);
    t_error(32'h300, "R4 owner clear gives error");
    t_status_write();
    mem[195] = cfgw(1, 1, 4'h5, 1, 1, 4); mem[196] = 32'h400; mem[197] = 32'hB00;
    t_error(32'h30C, "R5 bad mode gives error");
    t_nolaunch();
    chk(viol == 0, "R12 handshakes held until accepted", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule